// File: doc/BRIEF.md
# Dual-direction latched bus transceiver

This block joins two data ports, side A and side B, through a set of latch banks. There are `N_SEC` sections, each `SEC_W` bits wide. Each section has one bank that carries A-side data towards B and one bank that carries B-side data towards A. Each direction of each section has three active-low controls of its own: a section enable, a latch enable and an output enable. One direction can therefore capture, hold or present data while the other direction, or the other section, does something else.

The core is fully synchronous to `clk`. Each pin is split into a value coming in, a per-bit flag saying whether something outside drives it, a value going out and a per-bit drive enable. A pad wrapper resolves these into real tristate pins.

A per-bit keeper stands in for bus-hold. An input bit that nothing drives reads as the last level the pin had. The block's own output counts as a driver. The block has no flow control. Pins are level-based and cannot be stalled, so there is no valid/ready pair and no back-pressure. A latch bank takes whatever value the source pin has at each clock edge where it captures.

Top module: `dual_latch_xcvr`

## Requirements
- R1: An asynchronous low on `rst_n` clears every latch bank and every keeper to zero. With all controls high after reset, all outputs read zero and no drive enable is set.
- R2: While a direction's enable and latch enable are both low at a clock edge, its bank loads the resolved source pins at that edge. The data appears on the destination `*_out` bits one cycle later. The data is not inverted.
- R3: In the first cycle the latch enable is seen high, with the enable still low, the bank loads the source value present at that edge. Later source changes do not alter the bank.
- R4: In the first cycle the enable is seen high, with the latch enable still low, the bank loads the source value present at that edge. The bank then keeps that value.
- R5: Outside the cycles named in R2 to R4, a bank keeps its value unchanged.
- R6: The destination drive-enable bits of a section-direction are all set exactly when that direction's enable and output enable are both low. Otherwise they are all clear. `*_out` always shows the bank contents.
- R7: A high output enable does not prevent capture. A bank loads and holds data as in R2 to R4 while its outputs are released.
- R8: Section s occupies bits [s*SEC_W +: SEC_W] of every data port and bit s of every control port. Controls of one section or direction never affect another.
- R9: A source bit whose external drive flag is low resolves to the block's own output when the opposite direction drives that pin. Otherwise it resolves to the level the pin had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | N_SEC*SEC_W | Value driven onto A pins from outside |
| a_drv | input | N_SEC*SEC_W | Per-bit flag: A pin driven from outside |
| b_in | input | N_SEC*SEC_W | Value driven onto B pins from outside |
| b_drv | input | N_SEC*SEC_W | Per-bit flag: B pin driven from outside |
| en_ab_n | input | N_SEC | A-to-B section enable, active low |
| le_ab_n | input | N_SEC | A-to-B latch enable, active low |
| oe_ab_n | input | N_SEC | A-to-B output enable, active low |
| en_ba_n | input | N_SEC | B-to-A section enable, active low |
| le_ba_n | input | N_SEC | B-to-A latch enable, active low |
| oe_ba_n | input | N_SEC | B-to-A output enable, active low |
| a_out | output | N_SEC*SEC_W | B-to-A bank contents toward A pins |
| a_oe | output | N_SEC*SEC_W | Per-bit drive enable for A pins |
| b_out | output | N_SEC*SEC_W | A-to-B bank contents toward B pins |
| b_oe | output | N_SEC*SEC_W | Per-bit drive enable for B pins |

## Verification
Directed sequences close a bank in three different ways: by raising the latch enable, by raising the enable, and by leaving it open with the outputs released. Each sequence then changes the source, which shows whether capture stopped at the right edge. One step releases the source drivers while the bank is open, which shows whether the bank sees the keeper's held level. A long pseudo-random phase then toggles all twelve control lines and the drive flags independently. This exercises combinations such as simultaneous rises, and it mixes the two directions and sections. Any coupling between directions or sections would show up there. The bench never drives a pin the block is driving, and it flags contention if that ever happens.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DEF_N_SEC = 2;
  localparam int unsigned DEF_SEC_W = 8;

  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ext_val,
  input  logic [W-1:0] ext_drv,
  input  logic [W-1:0] own_val,
  input  logic         own_drv,
  output logic [W-1:0] pin
);
  logic [W-1:0] held_q;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (own_drv)         pin[i] = own_val[i];
      else if (ext_drv[i]) pin[i] = ext_val[i];
      else                 pin[i] = held_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= pin;
  end
endmodule

// File: rtl/xcvr_latch_dir.sv
module xcvr_latch_dir
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctrl_t    ctrl,
  input  logic [W-1:0] src,
  output logic [W-1:0] q,
  output logic         drive
);
  logic open_now;
  logic open_q;
  logic [W-1:0] bank_q;

  // transparent now, or was transparent last edge (closing edge of LE or E)
  assign open_now = !ctrl.en_n && !ctrl.le_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      bank_q <= '0;
    end else begin
      open_q <= open_now;
      if (open_now || open_q) bank_q <= src;
    end
  end

  assign q     = bank_q;
  assign drive = !ctrl.en_n && !ctrl.oe_n;
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned N_SEC = DEF_N_SEC,
  parameter int unsigned SEC_W = DEF_SEC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SEC*SEC_W-1:0] a_in,
  input  logic [N_SEC*SEC_W-1:0] a_drv,
  input  logic [N_SEC*SEC_W-1:0] b_in,
  input  logic [N_SEC*SEC_W-1:0] b_drv,
  input  logic [N_SEC-1:0]       en_ab_n,
  input  logic [N_SEC-1:0]       le_ab_n,
  input  logic [N_SEC-1:0]       oe_ab_n,
  input  logic [N_SEC-1:0]       en_ba_n,
  input  logic [N_SEC-1:0]       le_ba_n,
  input  logic [N_SEC-1:0]       oe_ba_n,
  output logic [N_SEC*SEC_W-1:0] a_out,
  output logic [N_SEC*SEC_W-1:0] a_oe,
  output logic [N_SEC*SEC_W-1:0] b_out,
  output logic [N_SEC*SEC_W-1:0] b_oe
);
  localparam int unsigned TOT_W = N_SEC * SEC_W;

  logic [TOT_W-1:0] a_pin;
  logic [TOT_W-1:0] b_pin;

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    dir_ctrl_t ctl_ab;
    dir_ctrl_t ctl_ba;
    logic      drv_ab;
    logic      drv_ba;
    logic [SEC_W-1:0] q_ab;
    logic [SEC_W-1:0] q_ba;

    assign ctl_ab = '{en_n: en_ab_n[s], le_n: le_ab_n[s], oe_n: oe_ab_n[s]};
    assign ctl_ba = '{en_n: en_ba_n[s], le_n: le_ba_n[s], oe_n: oe_ba_n[s]};

    xcvr_keeper #(.W(SEC_W)) u_keep_a (
      .clk(clk), .rst_n(rst_n),
      .ext_val(a_in[s*SEC_W +: SEC_W]), .ext_drv(a_drv[s*SEC_W +: SEC_W]),
      .own_val(q_ba), .own_drv(drv_ba),
      .pin(a_pin[s*SEC_W +: SEC_W])
    );

    xcvr_keeper #(.W(SEC_W)) u_keep_b (
      .clk(clk), .rst_n(rst_n),
      .ext_val(b_in[s*SEC_W +: SEC_W]), .ext_drv(b_drv[s*SEC_W +: SEC_W]),
      .own_val(q_ab), .own_drv(drv_ab),
      .pin(b_pin[s*SEC_W +: SEC_W])
    );

    xcvr_latch_dir #(.W(SEC_W)) u_ab (
      .clk(clk), .rst_n(rst_n), .ctrl(ctl_ab),
      .src(a_pin[s*SEC_W +: SEC_W]), .q(q_ab), .drive(drv_ab)
    );

    xcvr_latch_dir #(.W(SEC_W)) u_ba (
      .clk(clk), .rst_n(rst_n), .ctrl(ctl_ba),
      .src(b_pin[s*SEC_W +: SEC_W]), .q(q_ba), .drive(drv_ba)
    );

    assign b_out[s*SEC_W +: SEC_W] = q_ab;
    assign a_out[s*SEC_W +: SEC_W] = q_ba;
    assign b_oe[s*SEC_W +: SEC_W]  = {SEC_W{drv_ab}};
    assign a_oe[s*SEC_W +: SEC_W]  = {SEC_W{drv_ba}};
  end
endmodule

// File: rtl/dual_latch_xcvr_chk.sv
module dual_latch_xcvr_chk #(
  parameter int unsigned N_SEC = 2,
  parameter int unsigned SEC_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_SEC*SEC_W-1:0] a_in,
  input logic [N_SEC*SEC_W-1:0] a_drv,
  input logic [N_SEC*SEC_W-1:0] b_in,
  input logic [N_SEC*SEC_W-1:0] b_drv,
  input logic [N_SEC-1:0]       en_ab_n,
  input logic [N_SEC-1:0]       le_ab_n,
  input logic [N_SEC-1:0]       oe_ab_n,
  input logic [N_SEC-1:0]       en_ba_n,
  input logic [N_SEC-1:0]       le_ba_n,
  input logic [N_SEC-1:0]       oe_ba_n,
  input logic [N_SEC*SEC_W-1:0] a_out,
  input logic [N_SEC*SEC_W-1:0] a_oe,
  input logic [N_SEC*SEC_W-1:0] b_out,
  input logic [N_SEC*SEC_W-1:0] b_oe
);
  for (genvar s = 0; s < N_SEC; s++) begin : g_chk
    // R6
    b_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe[s*SEC_W +: SEC_W] != '0) |-> (!en_ab_n[s] && !oe_ab_n[s]));
    // R6
    a_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe[s*SEC_W +: SEC_W] != '0) |-> (!en_ba_n[s] && !oe_ba_n[s]));
    // R5
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_ab_n[s] == 1'b0 && $past(le_ab_n[s])) |=> $stable(b_out[s*SEC_W +: SEC_W]));
    // R5
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (le_ba_n[s] && $past(le_ba_n[s])) |=> $stable(a_out[s*SEC_W +: SEC_W]));
    // R2
    ab_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_ab_n[s] && !le_ab_n[s] && (&a_drv[s*SEC_W +: SEC_W]) && a_oe[s*SEC_W +: SEC_W] == '0)
      |=> b_out[s*SEC_W +: SEC_W] == $past(a_in[s*SEC_W +: SEC_W]));
    // R2
    ba_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_ba_n[s] && !le_ba_n[s] && (&b_drv[s*SEC_W +: SEC_W]) && b_oe[s*SEC_W +: SEC_W] == '0)
      |=> a_out[s*SEC_W +: SEC_W] == $past(b_in[s*SEC_W +: SEC_W]));
  end
endmodule

bind dual_latch_xcvr dual_latch_xcvr_chk #(.N_SEC(N_SEC), .SEC_W(SEC_W)) u_chk (.*);

// File: tb/dual_latch_xcvr_tb.sv
module dual_latch_xcvr_tb;
  localparam int NS = 2;
  localparam int W  = 8;
  localparam int T  = NS * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [T-1:0] a_in = '0, a_drv = '0, b_in = '0, b_drv = '0;
  logic [NS-1:0] en_ab_n = '1, le_ab_n = '1, oe_ab_n = '1;
  logic [NS-1:0] en_ba_n = '1, le_ba_n = '1, oe_ba_n = '1;
  logic [T-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  logic [W-1:0] m_ab [NS];
  logic [W-1:0] m_ba [NS];
  logic [W-1:0] k_a  [NS];
  logic [W-1:0] k_b  [NS];
  bit           was_ab [NS];
  bit           was_ba [NS];

  always #2 clk = ~clk;

  dual_latch_xcvr u_dut (.*);

  task automatic chk(input logic [T-1:0] act, input logic [T-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] resolve(input bit own, input logic [W-1:0] ownv,
                                           input logic [W-1:0] ev, input logic [W-1:0] ed,
                                           input logic [W-1:0] kv);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = own ? ownv[i] : (ed[i] ? ev[i] : kv[i]);
    return r;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        m_ab[s] = '0; m_ba[s] = '0; k_a[s] = '0; k_b[s] = '0;
        was_ab[s] = 0; was_ba[s] = 0;
      end
    end else begin
      for (int s = 0; s < NS; s++) begin
        logic [W-1:0] pa, pb;
        bit oab, oba;
        pa = resolve(!en_ba_n[s] && !oe_ba_n[s], m_ba[s], a_in[s*W +: W], a_drv[s*W +: W], k_a[s]);
        pb = resolve(!en_ab_n[s] && !oe_ab_n[s], m_ab[s], b_in[s*W +: W], b_drv[s*W +: W], k_b[s]);
        oab = !en_ab_n[s] && !le_ab_n[s];
        oba = !en_ba_n[s] && !le_ba_n[s];
        if (oab || was_ab[s]) m_ab[s] = pa;
        if (oba || was_ba[s]) m_ba[s] = pb;
        was_ab[s] = oab; was_ba[s] = oba;
        k_a[s] = pa; k_b[s] = pb;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [T-1:0] eb, ea, eob, eoa;
      for (int s = 0; s < NS; s++) begin
        eb[s*W +: W]  = m_ab[s];
        ea[s*W +: W]  = m_ba[s];
        eob[s*W +: W] = {W{!en_ab_n[s] && !oe_ab_n[s]}};
        eoa[s*W +: W] = {W{!en_ba_n[s] && !oe_ba_n[s]}};
      end
      chk(b_out, eb, "R2 b_out vs model");
      chk(a_out, ea, "R2 a_out vs model");
      chk(b_oe, eob, "R6 b_oe vs model");
      chk(a_oe, eoa, "R6 a_oe vs model");
      chk((a_drv & a_oe) | (b_drv & b_oe), '0, "R6 bus contention");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(b_out, '0, "R1 b_out after reset");
        chk(a_out, '0, "R1 a_out after reset");
        chk(b_oe | a_oe, '0, "R1 no drive after reset");
        cmp_on = 1'b1;

        // R2 / R7: transparent section 0 A-to-B with outputs released
        a_drv = '1; a_in = 16'h005A;
        en_ab_n[0] = 0; le_ab_n[0] = 0;
        step(1);
        chk(b_out[7:0], 8'h5A, "R2 transparent capture");
        chk(b_oe, '0, "R7 capture while released");

        // R3: LE rises with new data at that edge
        a_in = 16'h003C; le_ab_n[0] = 1;
        step(1);
        a_in = 16'h00FF;
        step(2);
        chk(b_out[7:0], 8'h3C, "R3 LE close stores value");
        chk(b_out[7:0], 8'h3C, "R5 hold after close");

        // R4: E rises while LE low
        le_ab_n[0] = 0; a_in = 16'h0011;
        step(1);
        a_in = 16'h0022; en_ab_n[0] = 1;
        step(1);
        a_in = 16'h0033;
        step(2);
        chk(b_out[7:0], 8'h22, "R4 E close stores value");

        // R6 / R8: enable outputs of section 0 only
        en_ab_n[0] = 0; le_ab_n[0] = 1; oe_ab_n[0] = 0;
        step(1);
        chk(b_oe, 16'h00FF, "R6 drive only section 0");
        chk(b_out, 16'h0022, "R8 section 1 untouched");

        // R9: keeper on undriven source
        oe_ab_n[0] = 1; le_ab_n[0] = 0; a_in = 16'h0077;
        step(1);
        a_drv = '0; a_in = 16'h0000;
        step(2);
        chk(b_out[7:0], 8'h77, "R9 keeper holds level");
        le_ab_n[0] = 1; en_ab_n[0] = 1;
        step(1);

        // random phase
        for (int c = 0; c < 4000; c++) begin
          logic [NS-1:0] drv_ab, drv_ba;
          en_ab_n = NS'($urandom); le_ab_n = NS'($urandom); oe_ab_n = NS'($urandom);
          en_ba_n = NS'($urandom); le_ba_n = NS'($urandom); oe_ba_n = NS'($urandom);
          drv_ab = ~en_ab_n & ~oe_ab_n;
          drv_ba = ~en_ba_n & ~oe_ba_n;
          a_in = T'($urandom); b_in = T'($urandom);
          a_drv = T'($urandom); b_drv = T'($urandom);
          for (int s = 0; s < NS; s++) begin
            if (drv_ba[s]) a_drv[s*W +: W] = '0;
            if (drv_ab[s]) b_drv[s*W +: W] = '0;
          end
          step(1);
        end
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule